// File: doc/BRIEF.md
# Teletext Line Request and Capture Controller

This controller sits between a raster timing generator and an external teletext byte source. Each line, it decides whether teletext may be inserted there. That depends on the field, a programmable line window for each field, a per-line disable mask and a global enable. On a qualifying line it opens a data span at a programmable pixel position. It then asks the external source for serial bits through a request strobe and captures the bits that come back after a programmable latency. The result goes to a downstream modulator as a bit stream with a valid flag.

The bit cadence comes from a fractional phase accumulator clocked at the pixel clock. A standard select sets both the accumulator step and the number of bits in a line. In the default mode the request strobe pulses once per bit. In window mode it stays high over the whole span, and the source paces itself. The capture points are the same in both modes.

Top module: `ttx_ins_ctl`

## Requirements
- R1: While `rst_n` is low, `ttx_req`, `bit_valid` and `bit_out` are 0.
- R2: With `ttx_en` low, no span starts, a running span stops at the next clock edge, and `ttx_req` is low in every cycle that follows a cycle with `ttx_en` low.
- R3: A line qualifies only if `line_num` lies between the first and last line registers (inclusive) of the current field: `field`=0 selects `odd_first`/`odd_last`, and `field`=1 selects `even_first`/`even_last`.
- R4: Bit i of `line_dis` (i = 0..23) disables line 23+i, so bit 0 stands for line 23. Lines outside 23..46 are never masked.
- R5: A span opens at the clock edge that samples `pix_cnt` equal to `hstart` on a qualifying line. In window mode `ttx_req` rises right after that edge.
- R6: In default mode (`win_mode`=0) each bit is requested by a one-cycle `ttx_req` pulse. A span has 360 bits for `std_sel`=0 (European, 625 lines), 288 for 1 (NABTS, 525 lines), 296 for 2 (WST, 525 lines) and 360 for 3 (WST, 625 lines).
- R7: Request points come from a 16-bit accumulator that adds 16839 each clock for `std_sel` 0 and 3, and 13902 for 1 and 2. A request fires on each carry, which gives spacings of 3 or 4 clocks (625-line standards) and 4 or 5 clocks (525-line standards).
- R8: The bit on `ttx_bit_in` is sampled `req_delay` clocks (0..15) after the cycle of its request. It appears on `bit_out` with `bit_valid` high for one cycle right after that sampling edge.
- R9: In window mode (`win_mode`=1), `ttx_req` stays high from the start of the span through the last bit's request point, as one pulse per line. The capture behaviour of R8 still holds.
- R10: A qualifying line produces exactly as many `bit_valid` pulses as the span length of R6, and a non-qualifying line produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttx_en | input | 1 | Global teletext enable |
| std_sel | input | 2 | Standard select (see R6) |
| win_mode | input | 1 | 1 = continuous request across the span |
| hstart | input | 8 | Pixel position that opens the span |
| req_delay | input | 4 | Clocks from request to valid source data |
| odd_first | input | 10 | First qualifying line, field 0 |
| odd_last | input | 10 | Last qualifying line, field 0 |
| even_first | input | 10 | First qualifying line, field 1 |
| even_last | input | 10 | Last qualifying line, field 1 |
| line_dis | input | 24 | Per-line disable mask, bit 0 = line 23 |
| line_num | input | 10 | Current line from the timing generator |
| pix_cnt | input | 11 | Current pixel in the line |
| field | input | 1 | Current field (0 or 1) |
| ttx_bit_in | input | 1 | Serial data from the teletext source |
| ttx_req | output | 1 | Request strobe to the source |
| bit_out | output | 1 | Captured teletext bit |
| bit_valid | output | 1 | `bit_out` holds a new bit |

## Verification
The assertions assume the following about the inputs. `pix_cnt` equals `hstart` at most once per line. A span finishes before the next line starts. `req_delay` and `std_sel` do not change between a request and its capture, so captured bits never come closer together than the minimum spacing. The stimulus keeps to this by changing all register inputs only between full 1716-pixel lines, while `hstart` and the span length keep every span and its latency tail inside the line.

// File: rtl/ttx_ins_ctl.sv
`timescale 1ns/1ps
module ttx_ins_ctl #(
  parameter int LINE_W         = 10,
  parameter int PIX_W          = 11,
  parameter int HS_W           = 8,
  parameter int DLY_W          = 4,
  parameter int ACC_W          = 16,
  parameter int DIS_W          = 24,
  parameter int FIRST_DIS_LINE = 23,
  parameter int INC_625        = 16839,
  parameter int INC_525        = 13902,
  parameter int BITS_EU        = 360,
  parameter int BITS_NABTS     = 288,
  parameter int BITS_WST525    = 296,
  parameter int BITS_WST625    = 360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ttx_en,
  input  logic [1:0]        std_sel,
  input  logic              win_mode,
  input  logic [HS_W-1:0]   hstart,
  input  logic [DLY_W-1:0]  req_delay,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  input  logic [DIS_W-1:0]  line_dis,
  input  logic [LINE_W-1:0] line_num,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic              field,
  input  logic              ttx_bit_in,
  output logic              ttx_req,
  output logic              bit_out,
  output logic              bit_valid
);
  localparam int MAX_A    = (BITS_EU > BITS_NABTS) ? BITS_EU : BITS_NABTS;
  localparam int MAX_B    = (BITS_WST525 > BITS_WST625) ? BITS_WST525 : BITS_WST625;
  localparam int MAX_BITS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int DIS_IW   = $clog2(DIS_W);
  localparam int HIST_W   = (1 << DLY_W) - 1;
  localparam logic [LINE_W-1:0] DIS_LO = LINE_W'(FIRST_DIS_LINE);
  localparam logic [LINE_W-1:0] DIS_HI = LINE_W'(FIRST_DIS_LINE + DIS_W);

  logic              active;
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  left;
  logic [HIST_W-1:0] hist;
  logic [ACC_W-1:0]  inc;
  logic [CNT_W-1:0]  nbits;
  logic [ACC_W:0]    sum;
  logic [LINE_W-1:0] dis_idx;
  logic              in_win, dis_hit, start, tick;
  logic [HIST_W:0]   dline;

  always_comb begin
    case (std_sel)
      2'd0:    begin inc = ACC_W'(INC_625); nbits = CNT_W'(BITS_EU);     end
      2'd1:    begin inc = ACC_W'(INC_525); nbits = CNT_W'(BITS_NABTS);  end
      2'd2:    begin inc = ACC_W'(INC_525); nbits = CNT_W'(BITS_WST525); end
      default: begin inc = ACC_W'(INC_625); nbits = CNT_W'(BITS_WST625); end
    endcase
  end

  assign in_win  = field ? (line_num >= even_first && line_num <= even_last)
                         : (line_num >= odd_first  && line_num <= odd_last);
  assign dis_idx = line_num - DIS_LO;
  assign dis_hit = (line_num >= DIS_LO) && (line_num < DIS_HI) && line_dis[dis_idx[DIS_IW-1:0]];
  assign start   = ttx_en && !active && in_win && !dis_hit && (pix_cnt == PIX_W'(hstart));
  assign sum     = {1'b0, acc} + {1'b0, inc};
  assign tick    = active && sum[ACC_W];
  assign dline   = {hist, tick};
  assign ttx_req = win_mode ? active : tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      acc    <= '0;
      left   <= '0;
    end else if (!ttx_en) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      acc    <= '0;
      left   <= nbits;
    end else if (active) begin
      acc <= sum[ACC_W-1:0];
      if (tick) begin
        left <= left - 1'b1;
        if (left == CNT_W'(1)) active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      hist      <= dline[HIST_W-1:0];
      bit_valid <= dline[req_delay];
      if (dline[req_delay]) bit_out <= ttx_bit_in;
    end
  end
endmodule

// File: rtl/ttx_ins_ctl_chk.sv
`timescale 1ns/1ps
module ttx_ins_ctl_chk #(
  parameter int PIX_W = 11,
  parameter int HS_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ttx_en,
  input logic             win_mode,
  input logic [3:0]       req_delay,
  input logic [HS_W-1:0]  hstart,
  input logic [PIX_W-1:0] pix_cnt,
  input logic             ttx_req,
  input logic             bit_valid
);
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ttx_en) |-> !ttx_req);

  assert_win_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mode && $past(win_mode) && $rose(ttx_req)) |-> ($past(pix_cnt) == PIX_W'($past(hstart))));

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_mode && ttx_req) |=> !(ttx_req && !win_mode));

  assert_valid_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  assert_zero_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_mode && ttx_req && req_delay == 4'd0) |=> bit_valid);
endmodule

bind ttx_ins_ctl ttx_ins_ctl_chk #(.PIX_W(PIX_W), .HS_W(HS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ttx_en(ttx_en), .win_mode(win_mode),
  .req_delay(req_delay), .hstart(hstart), .pix_cnt(pix_cnt),
  .ttx_req(ttx_req), .bit_valid(bit_valid)
);

// File: tb/ttx_ins_ctl_bench.sv
`timescale 1ns/1ps
module ttx_ins_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0, ttx_en = 1'b1, win_mode = 1'b0, field = 1'b0, ttx_bit_in = 1'b0;
  logic [1:0]  std_sel = 2'd0;
  logic [7:0]  hstart = 8'hA1;
  logic [3:0]  req_delay = 4'd2;
  logic [9:0]  odd_first = 10'd10, odd_last = 10'd50, even_first = 10'd300, even_last = 10'd320;
  logic [23:0] line_dis = 24'h800004;
  logic [9:0]  line_num = '0;
  logic [10:0] pix_cnt = '0;
  logic ttx_req, bit_out, bit_valid;

  ttx_ins_ctl u_ttx_ins_ctl (.*);

  always #10 clk = ~clk;

  int cyc = 0, nvec = 0, nbad = 0;
  int req_hi, req_rise, val_cnt, sp_bad, last_req, first_pix, sp_lo = 3, sp_hi = 4;
  logic prev_req = 1'b0;
  logic exp_q[$];
  bit done = 0;

  function automatic logic src_bit(int n);
    return logic'((n ^ (n >> 3) ^ (n >> 7)) & 1);
  endfunction

  function automatic int span_len(logic [1:0] s);
    case (s)
      2'd0: return 360;
      2'd1: return 288;
      2'd2: return 296;
      default: return 360;
    endcase
  endfunction

  always @(posedge clk) cyc = cyc + 1;
  always @(negedge clk) ttx_bit_in = src_bit(cyc);

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (ttx_req) begin
        req_hi++;
        if (!prev_req) begin
          req_rise++;
          if (req_rise == 1) first_pix = int'(pix_cnt);
        end
        if (!win_mode) begin
          exp_q.push_back(src_bit(cyc + int'(req_delay)));
          if (last_req >= 0 && (cyc - last_req < sp_lo || cyc - last_req > sp_hi)) sp_bad++;
          last_req = cyc;
        end
      end
      if (bit_valid) begin
        val_cnt++;
        if (exp_q.size() > 0) begin
          logic e;
          e = exp_q.pop_front();
          nvec++;
          if (bit_out !== e) begin
            nbad++;
            $display("FAIL R8 captured bit at cycle %0d: actual %b expected %b", cyc, bit_out, e);
          end
        end
      end
      prev_req = ttx_req;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_line(int ln, logic fld);
    req_hi = 0; req_rise = 0; val_cnt = 0; sp_bad = 0; last_req = -1; first_pix = -1;
    for (int p = 0; p < 1716; p++) begin
      @(negedge clk);
      pix_cnt  = 11'(p);
      line_num = 10'(ln);
      field    = fld;
    end
    @(negedge clk);
  endtask

  task automatic expect_plain(int n, string tag);
    check(req_rise == n, {tag, " request pulses"}, req_rise, n);
    check(req_hi == n, {tag, " request cycles"}, req_hi, n);
    check(val_cnt == n, {tag, " R10 valid count"}, val_cnt, n);
    check(sp_bad == 0, {tag, " R7 spacing violations"}, sp_bad, 0);
    check(exp_q.size() == 0, {tag, " R8 pending bits"}, exp_q.size(), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ttx_req == 0 && bit_valid == 0 && bit_out == 0, "R1 reset outputs",
          int'({ttx_req, bit_valid, bit_out}), 0);
    rst_n = 1'b1;

    run_line(22, 0);  expect_plain(span_len(2'd0), "R6 European line 22");
    run_line(25, 0);  expect_plain(0, "R4 line 25 masked by bit 2");
    run_line(10, 0);  expect_plain(360, "R3 odd first line 10");
    run_line(9, 0);   expect_plain(0, "R3 below odd window");
    run_line(50, 0);  expect_plain(360, "R3 odd last line 50");
    run_line(51, 0);  expect_plain(0, "R3 above odd window");
    run_line(46, 0);  expect_plain(0, "R4 line 46 masked by bit 23");
    run_line(47, 0);  expect_plain(360, "R4 line 47 outside mask");
    run_line(25, 1);  expect_plain(0, "R3 field 1 uses even window");
    run_line(300, 1); expect_plain(360, "R3 even window line 300");

    std_sel = 2'd1; req_delay = 4'd0; sp_lo = 4; sp_hi = 5;
    run_line(20, 0);  expect_plain(span_len(2'd1), "R6 NABTS delay 0");
    std_sel = 2'd2; req_delay = 4'd15;
    run_line(20, 0);  expect_plain(span_len(2'd2), "R6 WST525 delay 15");
    std_sel = 2'd3; req_delay = 4'd7; sp_lo = 3; sp_hi = 4;
    run_line(20, 0);  expect_plain(span_len(2'd3), "R6 WST625 delay 7");

    std_sel = 2'd0; req_delay = 4'd3; win_mode = 1'b1; hstart = 8'd200;
    run_line(20, 0);
    check(req_rise == 1, "R9 window single request pulse", req_rise, 1);
    check(first_pix == 200, "R5 window request start pixel", first_pix, 200);
    check(val_cnt == 360, "R9 window valid count", val_cnt, 360);
    check(req_hi > 1390 && req_hi < 1405, "R9 window request length", req_hi, 1401);

    win_mode = 1'b0; hstart = 8'hA1; ttx_en = 1'b0;
    run_line(20, 0);  expect_plain(0, "R2 enable low");
    ttx_en = 1'b1;
    run_line(20, 0);  expect_plain(360, "R2 enable restored");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule